// File: doc/BRIEF.md
# Replica-Checked Radix-2 Butterfly

This block is the arithmetic core of a radix-2 decimation-in-time FFT stage. Each cycle it can take one butterfly: two complex samples A and B and a complex twiddle W. It returns X = A + W·B and Y = A − W·B after a fixed pipeline delay. The twiddle product is built from four real multipliers, whose results feed two adders, and four more adders form X and Y. Multiplier outputs are kept only above a fixed number of dropped low bits, because the stage result is shortened again when it is written back.

Every real multiplier has a shadow multiplier. The shadow runs on operands that have their low bits cut off and keeps fewer product bits, so it is short enough to stay correct when the main multiplier gets timing faults from an aggressive supply or clock. A per-product check takes the difference between the main and shadow results. When the magnitude of that difference is beyond the largest value a fault-free main product can show, the shadow value replaces the main one before the sums. A four-bit flag vector reports which products were replaced. A fault-emulation input can invert the top bit of any main product, so that substitution can be exercised.

Top module: `rpr_bfly`

## Requirements
- R1: X = A·8 + P and Y = A·8 − P, where P real = p0 − p1 and P imaginary = p2 + p3. The products are p0 = Bre·Wre, p1 = Bim·Wim, p2 = Bre·Wim and p3 = Bim·Wre, each taken after selection. The twiddle is signed Q1.15 and A is weighted by 2^(15−12) = 8.
- R2: A main product is floor(b·w / 2^12), with a 10-bit signed sample b and a 16-bit signed twiddle part w, and is held as a 14-bit signed value.
- R3: A replica product is floor(floor(b/8)·floor(w/8) / 2^9)·8, on the same scale as the main product.
- R4: The replica replaces the main product when |main − replica| > 66, where 66 = floor(((2^9 + 2^15)·7 + 49) / 2^12) + 8 + 2. The corresponding flag is then set.
- R5: With no fault injected, no substitution happens and all flags are zero, for any input values.
- R6: out_valid rises exactly three clock cycles after in_valid was sampled high. One butterfly is accepted every cycle, with no stall.
- R7: subst_flags bit i belongs to product pi. The flags are registered together with X and Y, and they are all zero whenever out_valid is low.
- R8: With SATURATE = 0, each output component is a 15-bit signed value equal to the exact sum, with no wrap.
- R9: With SATURATE = 1, each output component is 14-bit signed and clamped to the range [−8192, 8191].
- R10: While rst_n is low at a clock edge, out_valid, subst_flags and all output components are cleared to zero.
- R11: err_inject bit i is sampled together with in_valid and inverts bit 13 (the top bit) of main product pi. Only flag i is set, and the output uses the replica value for that product only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A butterfly is present on the inputs this cycle |
| a_re | input | 10 | Sample A, real part, signed |
| a_im | input | 10 | Sample A, imaginary part, signed |
| b_re | input | 10 | Sample B, real part, signed |
| b_im | input | 10 | Sample B, imaginary part, signed |
| w_re | input | 16 | Twiddle, real part, signed Q1.15 |
| w_im | input | 16 | Twiddle, imaginary part, signed Q1.15 |
| err_inject | input | 4 | Fault emulation, one bit per main product |
| out_valid | output | 1 | X and Y hold a result |
| x_re | output | OUT_W (15) | A + W·B, real part |
| x_im | output | OUT_W (15) | A + W·B, imaginary part |
| y_re | output | OUT_W (15) | A − W·B, real part |
| y_im | output | OUT_W (15) | A − W·B, imaginary part |
| subst_flags | output | 4 | Replica substitution taken, per product |

## Verification
The assertions assume that in_valid is held low while reset is active, so that the three-cycle valid check never looks back at a value the reset discarded. The fault-free distance bound is checked only on cycles where no bit of err_inject is set. Error injection is the only way the stimulus can make a main product differ from its shadow by more than the threshold: every other operand pattern, including the full-scale extremes, is a legal fault-free input. The bench keeps in_valid low through reset and drives err_inject only as a deliberate fault.

// File: rtl/rpr_bfly_pkg.sv
// Shared helpers for the replica-checked butterfly.
// Assumes: two's complement operands, truncating (floor) shifts throughout.
package rpr_bfly_pkg;

    // Number of real products in one complex twiddle multiply.
    localparam int NPROD = 4;

    // Worst fault-free distance between a main product and its aligned
    // replica, in main-product LSBs. Operand truncation error plus the
    // floor error of both product truncations, plus one LSB of margin.
    function automatic int rpr_thresh(input int dw, input int tw, input int cut,
                                      input int mdrop, input int rdrop);
        longint lsb_err;
        longint raw;
        lsb_err = (longint'(1) <<< cut) - 1;
        raw = ((longint'(1) <<< (dw - 1)) + (longint'(1) <<< (tw - 1))) * lsb_err
              + lsb_err * lsb_err;
        return int'(raw >>> mdrop) + (1 <<< (2 * cut + rdrop - mdrop)) + 2;
    endfunction

endpackage

// File: rtl/rpr_mult_pair.sv
// One real multiplier with its reduced-precision shadow.
// The main product keeps bits above MAIN_DROP. The shadow multiplies
// operands with CUT low bits removed, drops REP_DROP more product bits, and
// is shifted back onto the main scale. Both results are registered when en
// is high. inject inverts the top bit of the main product (fault emulation).
// Assumes: 2*CUT + REP_DROP >= MAIN_DROP.
module rpr_mult_pair #(
    parameter int DATA_W    = 10,
    parameter int TWID_W    = 16,
    parameter int CUT       = 3,
    parameter int MAIN_DROP = 12,
    parameter int REP_DROP  = 9,
    parameter int THRESH    = 66,
    localparam int FULL_W   = DATA_W + TWID_W,
    localparam int MAIN_W   = FULL_W - MAIN_DROP,
    localparam int REP_W    = FULL_W - 2 * CUT,
    localparam int KEEP_W   = REP_W - REP_DROP,
    localparam int ALIGN    = 2 * CUT + REP_DROP - MAIN_DROP
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] b,
    input  logic signed [TWID_W-1:0] w,
    input  logic                     inject,
    output logic signed [MAIN_W-1:0] main_q,
    output logic signed [MAIN_W-1:0] rep_q
);

    localparam logic signed [MAIN_W:0] THR_S = (MAIN_W + 1)'(THRESH);

    logic signed [FULL_W-1:0]     full_c;
    logic signed [MAIN_W-1:0]     main_c;
    logic signed [MAIN_W-1:0]     main_x;
    logic signed [DATA_W-CUT-1:0] b_hi;
    logic signed [TWID_W-CUT-1:0] w_hi;
    logic signed [REP_W-1:0]      rep_full;
    logic signed [KEEP_W-1:0]     rep_keep;
    logic signed [MAIN_W-1:0]     rep_c;
    logic signed [MAIN_W:0]       gap_c;

    // Both products, truncated and aligned onto the main scale.
    always_comb begin
        full_c   = FULL_W'(b) * FULL_W'(w);
        main_c   = MAIN_W'(full_c >>> MAIN_DROP);
        main_x   = main_c ^ {inject, {(MAIN_W - 1){1'b0}}};
        b_hi     = (DATA_W - CUT)'(b >>> CUT);
        w_hi     = (TWID_W - CUT)'(w >>> CUT);
        rep_full = REP_W'(b_hi) * REP_W'(w_hi);
        rep_keep = KEEP_W'(rep_full >>> REP_DROP);
        rep_c    = MAIN_W'(rep_keep) <<< ALIGN;
        gap_c    = (MAIN_W + 1)'(main_c) - (MAIN_W + 1)'(rep_c);
    end

    // Product registers, loaded only for accepted butterflies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q <= '0;
            rep_q  <= '0;
        end else if (en) begin
            main_q <= main_x;
            rep_q  <= rep_c;
        end
    end

    // The threshold derivation covers every fault-free operand pair.
    p_fault_free_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !inject) |-> ((gap_c <= THR_S) && (gap_c >= -THR_S)));

endmodule

// File: rtl/rpr_err_ctrl.sv
// Error control for one product: subtract, compare the magnitude with the
// fault-free bound, and register either the main or the replica value.
// flag_o marks a substitution for the butterfly being carried.
// Assumes: main_i and rep_i are on the same scale.
module rpr_err_ctrl #(
    parameter int W      = 14,
    parameter int THRESH = 66
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                v_i,
    input  logic signed [W-1:0] main_i,
    input  logic signed [W-1:0] rep_i,
    output logic signed [W-1:0] sel_o,
    output logic                flag_o
);

    localparam logic [W:0] THR_U = (W + 1)'(THRESH);

    logic signed [W:0] diff_c;
    logic        [W:0] mag_c;
    logic              bad_c;

    // Distance between main and replica and the over-threshold decision.
    always_comb begin
        diff_c = (W + 1)'(main_i) - (W + 1)'(rep_i);
        mag_c  = diff_c[W] ? (W + 1)'(-diff_c) : (W + 1)'(diff_c);
        bad_c  = mag_c > THR_U;
    end

    // Selected product and substitution flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o  <= '0;
            flag_o <= 1'b0;
        end else begin
            flag_o <= v_i & bad_c;
            if (v_i) begin
                sel_o <= bad_c ? rep_i : main_i;
            end
        end
    end

    // A raised flag means the replica value was passed on.
    p_flag_takes_replica_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |-> (sel_o == $past(rep_i)));

    // Without a flag, a carried butterfly uses the main product.
    p_quiet_takes_main_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(v_i) && !flag_o) |-> (sel_o == $past(main_i)));

endmodule

// File: rtl/rpr_bfly_sum.sv
// Complex product adders and butterfly sums with the output register.
// Sums are formed exactly, MAIN_W+2 bits wide, then either passed at
// OUT_W = MAIN_W+1 (known wrap-free) or clamped to OUT_W = MAIN_W.
// Assumes: products are at most 2^(MAIN_W-2) in magnitude and A is
// shifted by ASH onto the product scale.
module rpr_bfly_sum #(
    parameter int  DATA_W   = 10,
    parameter int  MAIN_W   = 14,
    parameter int  ASH      = 3,
    parameter bit  SATURATE = 1'b0,
    localparam int OUT_W    = SATURATE ? MAIN_W : MAIN_W + 1,
    localparam int SW       = MAIN_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_i,
    input  logic signed [DATA_W-1:0] a_re,
    input  logic signed [DATA_W-1:0] a_im,
    input  logic signed [MAIN_W-1:0] p_rr,
    input  logic signed [MAIN_W-1:0] p_ii,
    input  logic signed [MAIN_W-1:0] p_ri,
    input  logic signed [MAIN_W-1:0] p_ir,
    input  logic [3:0]               flags_i,
    output logic                     v_o,
    output logic signed [OUT_W-1:0]  x_re,
    output logic signed [OUT_W-1:0]  x_im,
    output logic signed [OUT_W-1:0]  y_re,
    output logic signed [OUT_W-1:0]  y_im,
    output logic [3:0]               flags_o
);

    localparam logic signed [SW-1:0] HI = SW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [SW-1:0] LO = SW'(-(64'sd1 <<< (OUT_W - 1)));

    logic signed [SW-1:0]    as_re, as_im, pr_c, pi_c;
    logic signed [SW-1:0]    sum_c [4];
    logic signed [OUT_W-1:0] fit_c [4];

    // Complex product and the four exact butterfly sums.
    always_comb begin
        as_re    = SW'(a_re) <<< ASH;
        as_im    = SW'(a_im) <<< ASH;
        pr_c     = SW'(p_rr) - SW'(p_ii);
        pi_c     = SW'(p_ri) + SW'(p_ir);
        sum_c[0] = as_re + pr_c;
        sum_c[1] = as_im + pi_c;
        sum_c[2] = as_re - pr_c;
        sum_c[3] = as_im - pi_c;
    end

    for (genvar k = 0; k < 4; k++) begin : g_fit
        if (SATURATE) begin : g_clamp
            // Clamp the exact sum into the narrow output range.
            always_comb begin
                if (sum_c[k] > HI)      fit_c[k] = OUT_W'(HI);
                else if (sum_c[k] < LO) fit_c[k] = OUT_W'(LO);
                else                    fit_c[k] = OUT_W'(sum_c[k]);
            end
        end else begin : g_wide
            // The wide output keeps every value the sum can take.
            always_comb fit_c[k] = OUT_W'(sum_c[k]);

            p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
                v_i |-> ((sum_c[k] <= HI) && (sum_c[k] >= LO)));
        end
    end

    // Output register for results, valid and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o     <= 1'b0;
            x_re    <= '0;
            x_im    <= '0;
            y_re    <= '0;
            y_im    <= '0;
            flags_o <= '0;
        end else begin
            v_o     <= v_i;
            flags_o <= flags_i;
            if (v_i) begin
                x_re <= fit_c[0];
                x_im <= fit_c[1];
                y_re <= fit_c[2];
                y_im <= fit_c[3];
            end
        end
    end

    if (!SATURATE) begin : g_pair_chk
        // X + Y equals twice the scaled A in the exact mode.
        p_pair_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
            v_i |=> ((SW'(x_re) + SW'(y_re)) == ($past(as_re) <<< 1)));
    end

endmodule

// File: rtl/rpr_bfly.sv
// Replica-checked radix-2 DIT butterfly, one butterfly per cycle.
// Stage 1: four main/replica multiplier pairs. Stage 2: per-product error
// control. Stage 3: complex adds, butterfly sums and output register.
// Latency is three cycles. A and the valid strobe are delayed to match.
// Assumes: twiddle parts are signed Q1.(TWID_W-1) and in_valid is low
// during reset.
module rpr_bfly #(
    parameter int  DATA_W    = 10,
    parameter int  TWID_W    = 16,
    parameter int  CUT       = 3,
    parameter int  MAIN_DROP = 12,
    parameter int  REP_DROP  = 9,
    parameter bit  SATURATE  = 1'b0,
    localparam int MAIN_W    = DATA_W + TWID_W - MAIN_DROP,
    localparam int OUT_W     = SATURATE ? MAIN_W : MAIN_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] a_re,
    input  logic signed [DATA_W-1:0] a_im,
    input  logic signed [DATA_W-1:0] b_re,
    input  logic signed [DATA_W-1:0] b_im,
    input  logic signed [TWID_W-1:0] w_re,
    input  logic signed [TWID_W-1:0] w_im,
    input  logic [3:0]               err_inject,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  x_re,
    output logic signed [OUT_W-1:0]  x_im,
    output logic signed [OUT_W-1:0]  y_re,
    output logic signed [OUT_W-1:0]  y_im,
    output logic [3:0]               subst_flags
);

    import rpr_bfly_pkg::*;

    localparam int ASH    = TWID_W - 1 - MAIN_DROP;
    localparam int THRESH = rpr_thresh(DATA_W, TWID_W, CUT, MAIN_DROP, REP_DROP);

    logic signed [DATA_W-1:0] b_op [NPROD];
    logic signed [TWID_W-1:0] w_op [NPROD];
    logic signed [MAIN_W-1:0] main_s1 [NPROD];
    logic signed [MAIN_W-1:0] rep_s1 [NPROD];
    logic signed [MAIN_W-1:0] sel_s2 [NPROD];
    logic [NPROD-1:0]         flag_s2;
    logic                     v1, v2;
    logic signed [DATA_W-1:0] a_re1, a_im1, a_re2, a_im2;

    // Operand routing: p0 = Bre*Wre, p1 = Bim*Wim, p2 = Bre*Wim, p3 = Bim*Wre.
    always_comb begin
        b_op[0] = b_re; w_op[0] = w_re;
        b_op[1] = b_im; w_op[1] = w_im;
        b_op[2] = b_re; w_op[2] = w_im;
        b_op[3] = b_im; w_op[3] = w_re;
    end

    for (genvar k = 0; k < NPROD; k++) begin : g_prod
        rpr_mult_pair #(
            .DATA_W(DATA_W), .TWID_W(TWID_W), .CUT(CUT),
            .MAIN_DROP(MAIN_DROP), .REP_DROP(REP_DROP), .THRESH(THRESH)
        ) u_pair (
            .clk(clk), .rst_n(rst_n), .en(in_valid),
            .b(b_op[k]), .w(w_op[k]), .inject(err_inject[k]),
            .main_q(main_s1[k]), .rep_q(rep_s1[k])
        );

        rpr_err_ctrl #(.W(MAIN_W), .THRESH(THRESH)) u_ec (
            .clk(clk), .rst_n(rst_n), .v_i(v1),
            .main_i(main_s1[k]), .rep_i(rep_s1[k]),
            .sel_o(sel_s2[k]), .flag_o(flag_s2[k])
        );
    end

    // Valid strobe and A operand delay to line up with stage 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1    <= 1'b0;
            v2    <= 1'b0;
            a_re1 <= '0;
            a_im1 <= '0;
            a_re2 <= '0;
            a_im2 <= '0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            if (in_valid) begin
                a_re1 <= a_re;
                a_im1 <= a_im;
            end
            if (v1) begin
                a_re2 <= a_re1;
                a_im2 <= a_im1;
            end
        end
    end

    rpr_bfly_sum #(
        .DATA_W(DATA_W), .MAIN_W(MAIN_W), .ASH(ASH), .SATURATE(SATURATE)
    ) u_sum (
        .clk(clk), .rst_n(rst_n), .v_i(v2),
        .a_re(a_re2), .a_im(a_im2),
        .p_rr(sel_s2[0]), .p_ii(sel_s2[1]), .p_ri(sel_s2[2]), .p_ir(sel_s2[3]),
        .flags_i(flag_s2),
        .v_o(out_valid),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
        .flags_o(subst_flags)
    );

    // Fixed three-cycle latency of the valid strobe.
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 3));

    // Flags only accompany a valid result.
    p_flags_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|subst_flags) |-> out_valid);

endmodule

// File: tb/rpr_bfly_tb.sv
// Self-checking bench: directed corners plus seeded random butterflies,
// compared with a bench model written from the requirements.
module rpr_bfly_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic              in_valid;
    logic signed [9:0] a_re, a_im, b_re, b_im;
    logic signed [15:0] w_re, w_im;
    logic [3:0]        err_inject;

    logic               vw, vs;
    logic signed [14:0] xw_re, xw_im, yw_re, yw_im;
    logic signed [13:0] xs_re, xs_im, ys_re, ys_im;
    logic [3:0]         fw, fs;

    int checks = 0;
    int errors = 0;

    rpr_bfly u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .w_re(w_re), .w_im(w_im), .err_inject(err_inject),
        .out_valid(vw), .x_re(xw_re), .x_im(xw_im), .y_re(yw_re), .y_im(yw_im),
        .subst_flags(fw)
    );

    rpr_bfly #(.SATURATE(1'b1)) u_dut_sat (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .w_re(w_re), .w_im(w_im), .err_inject(err_inject),
        .out_valid(vs), .x_re(xs_re), .x_im(xs_im), .y_re(ys_re), .y_im(ys_im),
        .subst_flags(fs)
    );

    typedef struct {
        bit     v;
        longint xr, xi, yr, yi;
        bit [3:0] f;
        bit     noinj;
        string  tag;
    } exp_t;

    exp_t e1, e2, e3;

    task automatic cmp(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic longint sx(input int unsigned r, input int n);
        longint v;
        v = longint'(r) & ((64'sd1 <<< n) - 64'sd1);
        if (v >= (64'sd1 <<< (n - 1))) v = v - (64'sd1 <<< n);
        return v;
    endfunction

    // R2 main product, with the R11 top-bit inversion.
    function automatic longint main_p(input longint b, input longint w, input bit inj);
        longint v;
        v = (b * w) >>> 12;
        if (inj) begin
            v = (v & 64'h3FFF) ^ 64'h2000;
            if (v >= 64'h2000) v = v - 64'h4000;
        end
        return v;
    endfunction

    // R3 replica product.
    function automatic longint rep_p(input longint b, input longint w);
        return (((b >>> 3) * (w >>> 3)) >>> 9) <<< 3;
    endfunction

    function automatic longint clamp14(input longint v);
        if (v > 8191) return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    function automatic exp_t model(input bit v, input longint ar, input longint ai,
                                   input longint br, input longint bi,
                                   input longint wr, input longint wi,
                                   input bit [3:0] inj, input string tag);
        exp_t   e;
        longint bo [4];
        longint wo [4];
        longint sel [4];
        longint m, r, d, pr, pi;
        bo[0] = br; wo[0] = wr;
        bo[1] = bi; wo[1] = wi;
        bo[2] = br; wo[2] = wi;
        bo[3] = bi; wo[3] = wr;
        e.f = 4'b0000;
        for (int k = 0; k < 4; k++) begin
            m = main_p(bo[k], wo[k], inj[k]);
            r = rep_p(bo[k], wo[k]);
            d = (m > r) ? m - r : r - m;
            if (d > 66) begin
                sel[k] = r;
                e.f[k] = 1'b1;
            end else begin
                sel[k] = m;
            end
        end
        pr = sel[0] - sel[1];
        pi = sel[2] + sel[3];
        e.v = v;
        e.xr = ar * 8 + pr;
        e.xi = ai * 8 + pi;
        e.yr = ar * 8 - pr;
        e.yi = ai * 8 - pi;
        e.noinj = (inj == 4'b0000);
        e.tag = tag;
        if (!v) e.f = 4'b0000;
        return e;
    endfunction

    task automatic check_entry(input exp_t e);
        cmp({e.tag, " R6 out_valid"}, longint'(vw), longint'(e.v));
        cmp({e.tag, " R6 out_valid sat"}, longint'(vs), longint'(e.v));
        if (e.v) begin
            cmp({e.tag, " R1 R8 x_re"}, longint'(xw_re), e.xr);
            cmp({e.tag, " R1 R8 x_im"}, longint'(xw_im), e.xi);
            cmp({e.tag, " R1 R8 y_re"}, longint'(yw_re), e.yr);
            cmp({e.tag, " R1 R8 y_im"}, longint'(yw_im), e.yi);
            cmp({e.tag, " R9 x_re sat"}, longint'(xs_re), clamp14(e.xr));
            cmp({e.tag, " R9 x_im sat"}, longint'(xs_im), clamp14(e.xi));
            cmp({e.tag, " R9 y_re sat"}, longint'(ys_re), clamp14(e.yr));
            cmp({e.tag, " R9 y_im sat"}, longint'(ys_im), clamp14(e.yi));
            cmp({e.tag, " R4 R7 R11 flags"}, longint'(fw), longint'(e.f));
            cmp({e.tag, " R4 R7 R11 flags sat"}, longint'(fs), longint'(e.f));
            if (e.noinj) cmp({e.tag, " R5 no-fault flags"}, longint'(fw), 0);
        end else begin
            cmp({e.tag, " R7 idle flags"}, longint'(fw), 0);
        end
    endtask

    // One cycle: check the result due now, then apply the next butterfly.
    task automatic drive(input bit v, input longint ar, input longint ai,
                         input longint br, input longint bi,
                         input longint wr, input longint wi,
                         input bit [3:0] inj, input string tag);
        @(negedge clk);
        check_entry(e3);
        e3 = e2;
        e2 = e1;
        in_valid   = v;
        a_re       = 10'(ar);
        a_im       = 10'(ai);
        b_re       = 10'(br);
        b_im       = 10'(bi);
        w_re       = 16'(wr);
        w_im       = 16'(wi);
        err_inject = inj;
        e1 = model(v, ar, ai, br, bi, wr, wi, inj, tag);
    endtask

    task automatic drive_rand(input bit v, input bit [3:0] inj, input string tag);
        longint ar, ai, br, bi, wr, wi;
        ar = sx($urandom, 10);
        ai = sx($urandom, 10);
        br = sx($urandom, 10);
        bi = sx($urandom, 10);
        wr = sx($urandom, 16);
        wi = sx($urandom, 16);
        if ($urandom % 16 == 0) wr = -32768;
        if ($urandom % 16 == 0) wi = 32767;
        if ($urandom % 16 == 0) br = -512;
        drive(v, ar, ai, br, bi, wr, wi, inj, tag);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R6 watchdog: actual still running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240517);
        e1 = model(1'b0, 0, 0, 0, 0, 0, 0, 4'b0, "");
        e2 = e1;
        e3 = e1;
        rst_n = 1'b0;
        in_valid = 1'b0;
        a_re = '0; a_im = '0; b_re = '0; b_im = '0;
        w_re = '0; w_im = '0; err_inject = '0;
        repeat (4) @(negedge clk);
        cmp("R10 reset out_valid", longint'(vw), 0);
        cmp("R10 reset flags", longint'(fw), 0);
        cmp("R10 reset x_re", longint'(xw_re), 0);
        cmp("R10 reset y_im", longint'(yw_im), 0);
        cmp("R10 reset out_valid sat", longint'(vs), 0);
        rst_n = 1'b1;

        // Plain main product path, then the same product forced to the replica.
        drive(1'b1, 0, 0, 100, 0, 32767, 0, 4'b0000, "R2");
        drive(1'b1, 0, 0, 100, 0, 32767, 0, 4'b0001, "R3 R11");
        // Full-scale corners that drive the narrow output into the clamp.
        drive(1'b1, 511, 511, -512, -512, -32768, 32767, 4'b0000, "R9 high");
        drive(1'b1, -512, -512, -512, -512, -32768, 32767, 4'b0000, "R9 low");
        drive(1'b0, 0, 0, 0, 0, 0, 0, 4'b0000, "R6 gap");
        // Each product faulted on its own, then all four together.
        for (int k = 0; k < 4; k++) drive_rand(1'b1, 4'(1 << k), "R11 single");
        drive_rand(1'b1, 4'b1111, "R11 all");
        drive(1'b1, 0, 0, 0, 0, 0, 0, 4'b0000, "R1 zero");
        drive(1'b1, -512, 511, 511, -512, 32767, -32768, 4'b0000, "R5 corner");

        // Seeded random traffic with idle gaps and occasional faults.
        for (int i = 0; i < 3000; i++) begin
            bit       v;
            bit [3:0] inj;
            v = ($urandom % 8) != 0;
            inj = (($urandom % 8) == 0) ? 4'($urandom) : 4'b0000;
            drive_rand(v, inj, "rand");
        end

        for (int i = 0; i < 4; i++) drive(1'b0, 0, 0, 0, 0, 0, 0, 4'b0000, "flush");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule